// File: doc/BRIEF.md
# PCI Interrupt Mask and Summary Registers

This block gathers nineteen level-sensitive interrupt request lines from PCI slots and on-board functions. It presents them to a processor through three byte-wide registers on a small 8-bit I/O bus, which has an address, write data, read data, a read strobe and a write strobe.

A write to one of the three register offsets loads the matching byte of an internal mask, where a 1 blocks a line and a 0 lets it through. The mask is write-only. A read at the same offsets returns the live, synchronized request lines with no masking applied. The block drives a registered interrupt output whenever any unmasked line is pending. It also drives the index of the lowest-numbered pending unmasked line and a valid flag, so that software services lines in a fixed order.

Line 4 carries the cascade from a secondary legacy interrupt controller. The block treats it as an ordinary request bit, so its place in the service order comes only from its bit position.

Top module: `pci_irq_summary`

## Requirements
- R1: After reset all nineteen mask bits are 1, `irq_out` is 0 and `lowest_vld` is 0. With every line requesting and no mask write, `irq_out` stays 0.
- R2: A mask bit of 1 disables its line and a mask bit of 0 enables it. A pending line whose mask bit is 1 neither raises `irq_out` nor appears on `lowest_idx`.
- R3: A write at offset 4, 5 or 6 loads mask bits 0–7, 8–15 or 16–18 respectively from `wdata`. At offset 6 only `wdata[2:0]` is used.
- R4: A read at offset 4, 5 or 6 returns synchronized request bits 0–7, 8–15 or 16–18, with bit n of the byte holding request 8·k+n. The result does not depend on the mask. When `rd_en` is 0, `rdata` is 0.
- R5: At offset 6, `rdata[7:3]` always reads 0.
- R6: A write to any offset other than 4, 5 or 6 leaves the mask unchanged. A read at such an offset returns 0.
- R7: `irq_out` is registered. It is 1 exactly when, in the previous cycle, some synchronized request had a 0 mask bit. A mask write therefore changes `irq_out` at the clock edge after the write edge.
- R8: `lowest_idx` holds the smallest index among the pending unmasked lines, and `lowest_vld` is 1 whenever there is at least one such line. Both are registered alongside `irq_out`. The cascade line (bit 4) has no priority beyond its index.
- R9: Request inputs pass through two flip-flops. A change on `req_in` reaches `rdata` after two rising edges and reaches `irq_out` after three.
- R10: Requests are level-sensitive. A line stays pending for as long as it is held high, and it stops being pending once it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NREQ (19) | Asynchronous level request lines |
| addr | input | ADDR_W (4) | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, read data is combinational |
| rdata | output | 8 | Read data |
| irq_out | output | 1 | Any unmasked request pending |
| lowest_idx | output | IDX_W (5) | Index of the lowest pending unmasked line |
| lowest_vld | output | 1 | `lowest_idx` is meaningful |

## Verification
The assertions check on every cycle that the outputs agree with each other and with the state one cycle earlier. This covers `irq_out` matching `lowest_vld`, the chosen index being the lowest bit of the previous pending set, silence while every mask bit is set, and zero read data for reserved bits, unmapped offsets and idle strobes. Only the bench scenarios can show the register layout and how writes and reads map to it. They also cover the exact two- and three-edge latencies, the fact that unmapped writes leave the mask untouched, and the lowest-first order across every pair of lines.

// File: rtl/pci_irq_summary.sv
module pci_irq_summary #(
  parameter int ADDR_W   = 4,
  parameter int NREQ     = 19,
  parameter int BASE_OFS = 4,
  localparam int NBYTES  = (NREQ + 7) / 8,
  localparam int PAD     = NBYTES * 8,
  localparam int IDX_W   = $clog2(NREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              irq_out,
  output logic [IDX_W-1:0]  lowest_idx,
  output logic              lowest_vld
);

  logic [NREQ-1:0]  req_s1, req_s2, mask_q, pend;
  logic [PAD-1:0]   req_pad;
  logic [IDX_W-1:0] lo_idx;
  logic             lo_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_s1 <= '0;
      req_s2 <= '0;
    end else begin
      req_s1 <= req_in;
      req_s2 <= req_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '1;
    else if (wr_en)
      for (int i = 0; i < NREQ; i++)
        if (addr == ADDR_W'(BASE_OFS + i / 8)) mask_q[i] <= wdata[i % 8];

  assign req_pad = PAD'(req_s2);

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBYTES; b++)
      if (rd_en && addr == ADDR_W'(BASE_OFS + b)) rdata = req_pad[b*8 +: 8];
  end

  assign pend = req_s2 & ~mask_q;

  always_comb begin
    lo_idx = '0;
    lo_hit = 1'b0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (pend[i]) begin
        lo_idx = IDX_W'(i);
        lo_hit = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_out    <= 1'b0;
      lowest_idx <= '0;
      lowest_vld <= 1'b0;
    end else begin
      irq_out    <= |pend;
      lowest_idx <= lo_idx;
      lowest_vld <= lo_hit;
    end

endmodule

// File: rtl/pci_irq_summary_chk.sv
module pci_irq_summary_chk #(
  parameter int ADDR_W   = 4,
  parameter int NREQ     = 19,
  parameter int BASE_OFS = 4,
  parameter int IDX_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              irq_out,
  input logic [IDX_W-1:0]  lowest_idx,
  input logic              lowest_vld,
  input logic [NREQ-1:0]   mask_q,
  input logic [NREQ-1:0]   req_s2
);

  logic [NREQ-1:0] pend_p, below;
  logic            oor;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_p <= '0;
    else        pend_p <= req_s2 & ~mask_q;

  assign below = (NREQ'(1) << lowest_idx) - NREQ'(1);
  assign oor   = (int'(addr) < BASE_OFS) || (int'(addr) > BASE_OFS + (NREQ - 1) / 8);

  assert_irq_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == lowest_vld);

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lowest_vld |-> (int'(lowest_idx) < NREQ));

  assert_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lowest_vld |-> (pend_p[lowest_idx] && ((pend_p & below) == '0)));

  assert_all_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(mask_q)) |-> !irq_out);

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) == BASE_OFS + (NREQ - 1) / 8) |-> ((rdata >> (NREQ % 8)) == 8'd0));

  assert_oor_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && oor) |-> (rdata == 8'd0));

  assert_idle_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'd0));

endmodule

bind pci_irq_summary pci_irq_summary_chk #(
  .ADDR_W(ADDR_W), .NREQ(NREQ), .BASE_OFS(BASE_OFS), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rdata(rdata),
  .irq_out(irq_out), .lowest_idx(lowest_idx), .lowest_vld(lowest_vld),
  .mask_q(mask_q), .req_s2(req_s2)
);

// File: tb/pci_irq_summary_tb_top.sv
module pci_irq_summary_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [18:0] req_in = '0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        irq_out, lowest_vld;
  logic [4:0]  lowest_idx;
  int          n_run = 0, n_fail = 0;

  pci_irq_summary dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out),
    .lowest_idx(lowest_idx), .lowest_vld(lowest_vld)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    addr = 4'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    addr = 4'(a); rd_en = 1'b1;
    #1;
    chk(rdata == 8'(exp), tag, int'(rdata), exp);
    rd_en = 1'b0;
  endtask

  function automatic int byte_of(input logic [18:0] r, input int b);
    logic [23:0] w;
    w = 24'(r);
    return int'(w[b*8 +: 8]);
  endfunction

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(irq_out == 1'b0, "R1 irq after reset", int'(irq_out), 0);
    chk(lowest_vld == 1'b0, "R1 vld after reset", int'(lowest_vld), 0);
    rd_chk(5, 0, "R4 idle read");

    req_in = '1;
    tick(4);
    chk(irq_out == 1'b0, "R1 all masked at reset", int'(irq_out), 0);
    rd_chk(4, 8'hFF, "R4 read off4 masked");
    rd_chk(5, 8'hFF, "R4 read off5 masked");
    rd_chk(6, 8'h07, "R5 reserved bits off6");
    addr = 4'd4; #1;
    chk(rdata == 8'd0, "R4 rd_en low gives 0", int'(rdata), 0);

    for (int a = 0; a < 16; a++) begin
      if (a >= 4 && a <= 6) continue;
      wr(a, 0);
      rd_chk(a, 0, "R6 unmapped read");
    end
    tick(2);
    chk(irq_out == 1'b0, "R6 unmapped writes ignored", int'(irq_out), 0);

    wr(6, 8'hF8);
    tick(1);
    chk(irq_out == 1'b1 && lowest_idx == 5'd16, "R3 off6 low bits enable 16", int'(lowest_idx), 16);
    wr(6, 8'h07);
    wr(4, 8'hEF);
    tick(1);
    chk(lowest_vld && lowest_idx == 5'd4, "R8 cascade bit 4 alone", int'(lowest_idx), 4);
    wr(4, 8'hFF);
    wr(5, 8'hFE);
    tick(1);
    chk(lowest_vld && lowest_idx == 5'd8, "R3 off5 bit0 is line 8", int'(lowest_idx), 8);
    wr(5, 8'hFF);
    tick(1);
    chk(irq_out == 1'b0, "R2 remasked", int'(irq_out), 0);

    req_in = 19'h5A5A5;
    tick(3);
    for (int b = 0; b < 3; b++) rd_chk(4 + b, byte_of(19'h5A5A5, b), "R4 readback ignores mask");

    wr(4, 0); wr(5, 0); wr(6, 0);
    for (int i = 0; i < 19; i++) begin
      req_in = 19'(1) << i;
      tick(4);
      chk(irq_out == 1'b1, "R2 single enabled line irq", int'(irq_out), 1);
      chk(lowest_idx == 5'(i) && lowest_vld, "R8 single line index", int'(lowest_idx), i);
      rd_chk(4 + i / 8, 1 << (i % 8), "R4 single line readback");
      wr(4 + i / 8, 1 << (i % 8));
      tick(1);
      chk(irq_out == 1'b0, "R2 masked single line", int'(irq_out), 0);
      wr(4 + i / 8, 0);
    end

    for (int i = 0; i < 19; i++)
      for (int j = i + 1; j < 19; j++) begin
        req_in = (19'(1) << i) | (19'(1) << j);
        tick(3);
        chk(lowest_vld && lowest_idx == 5'(i), "R8 lowest of pair", int'(lowest_idx), i);
      end

    req_in = '0;
    tick(4);
    req_in = 19'(1) << 10;
    tick(1);
    rd_chk(5, 0, "R9 not yet after one edge");
    tick(1);
    rd_chk(5, 8'h04, "R9 readback after two edges");
    chk(irq_out == 1'b0, "R9 irq not after two edges", int'(irq_out), 0);
    tick(1);
    chk(irq_out == 1'b1 && lowest_idx == 5'd10, "R9 irq after three edges", int'(lowest_idx), 10);

    wr(5, 8'h04);
    chk(irq_out == 1'b1, "R7 irq holds at mask write edge", int'(irq_out), 1);
    tick(1);
    chk(irq_out == 1'b0, "R7 irq drops one edge later", int'(irq_out), 0);
    wr(5, 0);
    tick(1);
    chk(irq_out == 1'b1, "R7 irq returns after unmask", int'(irq_out), 1);

    tick(10);
    chk(irq_out == 1'b1, "R10 held level stays pending", int'(irq_out), 1);
    req_in = '0;
    tick(3);
    chk(irq_out == 1'b0 && !lowest_vld, "R10 released line clears", int'(irq_out), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule